// File: doc/BRIEF.md
# Peer Setup Message Decoder

This block sits behind the byte stream that a control server sends to a shared-memory peer device. It gathers bytes into 64-bit little-endian messages. A side flag, taken with the eighth byte, tells whether a handle travelled with the message. The block runs the setup handshake in a fixed order: a protocol version word, then the device's own ID, then any mix of peer messages until the shared-memory message (value -1) arrives. After setup it goes on classifying messages as they come. A repeated shared-memory message is an error. A peer message with a handle is a connect, and one without a handle is a disconnect.

For every peer the block keeps the number of vectors registered so far. The N-th connect for a peer implicitly names vector N-1. It also keeps the current peer count, which grows when a message names a peer past it. Each accepted message, and each rejected one, gives a one-cycle event pulse. A connect that names the device's own ID also gives a local-vector-enable pulse carrying the vector number. A rule broken during setup leaves the block in a failed state that ignores all further traffic until reset. After setup a broken rule only gives the error pulse. Mapping the memory and handling the handles are left to the logic around the block.

Top module: `peer_setup_decoder`

## Requirements
- R1: Bytes with `in_valid` high fill a message least-significant byte first. The eighth byte completes it, and `in_handle` is sampled together with that eighth byte. The resulting event outputs change on the second rising clock edge after the eighth byte is taken, and no sooner.
- R2: After reset: `own_id` is 0, `setup_done` and `setup_failed` are 0, `peer_count` is 16, every vector count is 0 and no pulse output is high. Peer p's count sits at `vec_counts[p*VCW +: VCW]`, with VCW = clog2(MAX_VEC+1), which is 3 by default.
- R3: The first message must equal PROTO_VER (default 0) and have no handle. Otherwise `err_pulse` fires and `setup_failed` becomes 1.
- R4: The second message becomes `own_id` (its low 16 bits). It must have no handle and a value from 0 to 65535. When `cfg_master` is 1 it must also be 0. Otherwise setup fails with `err_pulse`.
- R5: After the ID, the value -1 (all ones) gives `shm_evt` and sets `setup_done`, which stays set. Any later -1 gives `err_pulse` and no `shm_evt`.
- R6: A value below -1 or above 65535 gives `err_pulse` and changes no state. If it arrives before setup is done, setup fails.
- R7: A peer message naming peer p ≥ `peer_count` first raises `peer_count` to p+1. The new peers start at zero vectors. A peer p ≥ MAX_PEERS (default 32) is rejected with `err_pulse` and changes nothing.
- R8: A connect (handle present) increments peer p's count and gives `conn_evt` with `evt_peer` = p. When the count is already MAX_VEC (default 4), it gives `err_pulse` and the count is unchanged.
- R9: A connect naming `own_id` also gives `lvec_en`, with `lvec_num` equal to the count before the increment.
- R10: A disconnect (no handle) clears peer p's count and gives `disc_evt`. A disconnect naming `own_id` gives `err_pulse` and leaves the count unchanged.
- R11: Once `setup_failed` is 1, messages change no output and raise no pulse until reset.
- R12: Every message raises exactly one of `shm_evt`, `conn_evt`, `disc_evt`, `err_pulse`, for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A byte is present on `in_byte` |
| in_byte | input | 8 | Stream byte |
| in_handle | input | 1 | Handle flag, taken with the eighth byte |
| cfg_master | input | 1 | Device is configured as master |
| own_id | output | 16 | Captured own ID |
| setup_done | output | 1 | Shared-memory message accepted |
| setup_failed | output | 1 | Setup broke a rule; traffic ignored |
| peer_count | output | PCW | Current number of peers |
| vec_counts | output | MAX_PEERS*VCW | Per-peer registered vector counts |
| shm_evt | output | 1 | Shared-memory message accepted |
| conn_evt | output | 1 | Connect accepted |
| disc_evt | output | 1 | Disconnect accepted |
| evt_peer | output | 16 | Peer named by the current message |
| lvec_en | output | 1 | Own vector registered |
| lvec_num | output | VCW | Number of that vector |
| err_pulse | output | 1 | Message rejected |

## Verification
A byte counter that drifts by one shifts every later value by a byte. The shift first shows in `own_id` and then as errors on the very next message, two cycles after its last byte. A wrong per-peer count shows either as a wrong `lvec_num` or as a wrong `vec_counts` field. It can also stay hidden until the cap is reached, when a connect is rejected one vector too early or too late. A setup state that is wrong shows on the message that follows: pulses appear where the failed state should be quiet, or `setup_done` rises on the wrong -1.

// File: rtl/psd_pkg.sv
// Shared types and constants for the peer setup message decoder.
package psd_pkg;
    localparam int MSG_BYTES = 8;
    localparam int MSG_W     = MSG_BYTES * 8;
    localparam int BCW       = $clog2(MSG_BYTES);
    localparam int ID_W      = 16;
    localparam int INIT_PEERS = 16;

    typedef enum logic [2:0] {
        ST_VER  = 3'd0,
        ST_ID   = 3'd1,
        ST_WAIT = 3'd2,
        ST_RUN  = 3'd3,
        ST_FAIL = 3'd4
    } psd_state_e;
endpackage

// File: rtl/psd_asm.sv
// Byte-to-message assembler.
// Collects MSG_BYTES bytes least-significant first and presents the message
// with its handle flag for one cycle after the last byte.
// Assumes: in_handle is meaningful only with the last byte of a message.
module psd_asm
    import psd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    input  logic             in_handle,
    output logic             msg_v,
    output logic [MSG_W-1:0] msg,
    output logic             msg_hnd
);
    logic [BCW-1:0]   cnt;
    logic [MSG_W-9:0] hold;

    // Count bytes, hold partial message, emit on the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            hold    <= '0;
            msg     <= '0;
            msg_hnd <= 1'b0;
            msg_v   <= 1'b0;
        end else begin
            msg_v <= 1'b0;
            if (in_valid) begin
                if (cnt == BCW'(MSG_BYTES - 1)) begin
                    msg     <= {in_byte, hold};
                    msg_hnd <= in_handle;
                    msg_v   <= 1'b1;
                    cnt     <= '0;
                end else begin
                    hold[{cnt, 3'b000} +: 8] <= in_byte;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/psd_class.sv
// Message classifier.
// Splits a 64-bit message value into: shared-memory marker (-1), out of the
// accepted range (below -1 or above 65535), and peer index with storage check.
// Assumes: pure combinational, no state.
module psd_class
    import psd_pkg::*;
#(
    parameter int MAX_PEERS = 32
) (
    input  logic [MSG_W-1:0] msg,
    output logic             is_shm,
    output logic             bad_range,
    output logic             beyond,
    output logic [ID_W-1:0]  pid
);
    // Decode value class; any set bit above the ID field means out of range.
    always_comb begin
        is_shm    = &msg;
        bad_range = !is_shm && (|msg[MSG_W-1:ID_W]);
        pid       = msg[ID_W-1:0];
        beyond    = 32'(pid) >= MAX_PEERS;
    end
endmodule

// File: rtl/psd_peers.sv
// Per-peer vector counter bank.
// One counter per storage slot. inc adds one, clr zeroes, both act on idx.
// Assumes: inc and clr are never high together and inc is not given at MAX_VEC.
module psd_peers #(
    parameter int MAX_PEERS = 32,
    parameter int MAX_VEC   = 4,
    localparam int IW  = $clog2(MAX_PEERS),
    localparam int VCW = $clog2(MAX_VEC + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inc,
    input  logic                     clr,
    input  logic [IW-1:0]            idx,
    output logic [MAX_PEERS*VCW-1:0] counts,
    output logic [VCW-1:0]           sel_cnt
);
    for (genvar g = 0; g < MAX_PEERS; g++) begin : g_slot
        // Update slot g when it is the addressed peer.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                counts[g*VCW +: VCW] <= '0;
            end else if (idx == IW'(g)) begin
                if (clr)      counts[g*VCW +: VCW] <= '0;
                else if (inc) counts[g*VCW +: VCW] <= counts[g*VCW +: VCW] + 1'b1;
            end
        end
    end

    // Read the addressed counter.
    always_comb sel_cnt = counts[idx*VCW +: VCW];
endmodule

// File: rtl/peer_setup_decoder.sv
// Peer setup message decoder (top).
// Runs version -> ID -> wait-for-shared-memory setup, then classifies every
// message, keeps per-peer vector counts and the peer count, and raises
// one-cycle event pulses. Setup errors park the block in a failed state.
// Assumes: MAX_PEERS >= 16; handles themselves are managed outside.
module peer_setup_decoder
    import psd_pkg::*;
#(
    parameter int MAX_PEERS = 32,
    parameter int MAX_VEC   = 4,
    parameter logic [63:0] PROTO_VER = 64'd0,
    localparam int IW  = $clog2(MAX_PEERS),
    localparam int VCW = $clog2(MAX_VEC + 1),
    localparam int PCW = $clog2(MAX_PEERS + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [7:0]               in_byte,
    input  logic                     in_handle,
    input  logic                     cfg_master,
    output logic [15:0]              own_id,
    output logic                     setup_done,
    output logic                     setup_failed,
    output logic [PCW-1:0]           peer_count,
    output logic [MAX_PEERS*VCW-1:0] vec_counts,
    output logic                     shm_evt,
    output logic                     conn_evt,
    output logic                     disc_evt,
    output logic [15:0]              evt_peer,
    output logic                     lvec_en,
    output logic [VCW-1:0]           lvec_num,
    output logic                     err_pulse
);
    psd_state_e state, nxt;
    logic             msg_v, msg_hnd;
    logic [MSG_W-1:0] msg;
    logic             is_shm, bad_range, beyond;
    logic [ID_W-1:0]  pid;
    logic [VCW-1:0]   sel_cnt;
    logic bad, ok_shm, do_inc, do_clr, do_grow, id_ld;

    psd_asm u_asm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_handle(in_handle), .msg_v(msg_v), .msg(msg), .msg_hnd(msg_hnd)
    );

    psd_class #(.MAX_PEERS(MAX_PEERS)) u_class (
        .msg(msg), .is_shm(is_shm), .bad_range(bad_range),
        .beyond(beyond), .pid(pid)
    );

    psd_peers #(.MAX_PEERS(MAX_PEERS), .MAX_VEC(MAX_VEC)) u_peers (
        .clk(clk), .rst_n(rst_n), .inc(do_inc), .clr(do_clr),
        .idx(pid[IW-1:0]), .counts(vec_counts), .sel_cnt(sel_cnt)
    );

    // Decide the action for the message presented this cycle.
    always_comb begin
        nxt = state; bad = 1'b0; ok_shm = 1'b0; do_inc = 1'b0;
        do_clr = 1'b0; do_grow = 1'b0; id_ld = 1'b0;
        if (msg_v) begin
            case (state)
                ST_VER: begin
                    if (msg == PROTO_VER && !msg_hnd) nxt = ST_ID;
                    else bad = 1'b1;
                end
                ST_ID: begin
                    if (msg_hnd || bad_range || is_shm) bad = 1'b1;
                    else if (cfg_master && pid != '0) bad = 1'b1;
                    else begin
                        id_ld = 1'b1;
                        nxt   = ST_WAIT;
                    end
                end
                ST_WAIT, ST_RUN: begin
                    if (bad_range) begin
                        bad = 1'b1;
                    end else if (is_shm) begin
                        if (state == ST_RUN) bad = 1'b1;
                        else begin
                            ok_shm = 1'b1;
                            nxt    = ST_RUN;
                        end
                    end else if (beyond) begin
                        bad = 1'b1;
                    end else begin
                        do_grow = 32'(pid) >= 32'(peer_count);
                        if (msg_hnd) begin
                            if (sel_cnt >= VCW'(MAX_VEC)) bad = 1'b1;
                            else do_inc = 1'b1;
                        end else if (pid == own_id) begin
                            bad = 1'b1;
                        end else begin
                            do_clr = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if (bad && state != ST_RUN) nxt = ST_FAIL;
        end
    end

    // Register state, captured ID, peer count and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_VER;
            own_id     <= '0;
            peer_count <= PCW'(INIT_PEERS);
            shm_evt    <= 1'b0;
            conn_evt   <= 1'b0;
            disc_evt   <= 1'b0;
            err_pulse  <= 1'b0;
            lvec_en    <= 1'b0;
            lvec_num   <= '0;
            evt_peer   <= '0;
        end else begin
            state     <= nxt;
            shm_evt   <= ok_shm;
            conn_evt  <= do_inc;
            disc_evt  <= do_clr;
            err_pulse <= bad;
            lvec_en   <= do_inc && (pid == own_id);
            lvec_num  <= sel_cnt;
            evt_peer  <= pid;
            if (id_ld)   own_id     <= pid;
            if (do_grow) peer_count <= PCW'(pid) + 1'b1;
        end
    end

    // Status flags come straight from the state register.
    always_comb begin
        setup_done   = (state == ST_RUN);
        setup_failed = (state == ST_FAIL);
    end
endmodule

// File: rtl/peer_setup_decoder_chk.sv
// Property checker for peer_setup_decoder, attached by bind.
// Assumes: observes ports only.
module peer_setup_decoder_chk #(
    parameter int MAX_PEERS = 32,
    parameter int MAX_VEC   = 4,
    localparam int VCW = $clog2(MAX_VEC + 1),
    localparam int PCW = $clog2(MAX_PEERS + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [15:0]              own_id,
    input logic                     setup_done,
    input logic                     setup_failed,
    input logic [PCW-1:0]           peer_count,
    input logic [MAX_PEERS*VCW-1:0] vec_counts,
    input logic                     shm_evt,
    input logic                     conn_evt,
    input logic                     disc_evt,
    input logic [15:0]              evt_peer,
    input logic                     lvec_en,
    input logic                     err_pulse
);
    // R12: at most one outcome per cycle.
    a_r12_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shm_evt, conn_evt, disc_evt, err_pulse}));

    // R9: local enable only with a connect to the own ID.
    a_r9_local_is_own: assert property (@(posedge clk) disable iff (!rst_n)
        lvec_en |-> (conn_evt && evt_peer == own_id));

    // R7: peer count never shrinks.
    a_r7_count_grows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (peer_count >= $past(peer_count)));

    // R5: setup done is sticky and no second shared-memory event.
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        setup_done |=> setup_done);
    a_r5_single_shm: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_done && $past(setup_done)) |-> !shm_evt);

    // R11: failed state stays quiet after the failing message.
    a_r11_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_failed && $past(setup_failed)) |->
            !(shm_evt || conn_evt || disc_evt || err_pulse));

    // R2: done and failed never both set.
    a_r2_flags_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(setup_done && setup_failed));

    // R8: no per-peer count above the vector limit.
    always @(posedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < MAX_PEERS; p++) begin
                a_r8_cap: assert (32'(vec_counts[p*VCW +: VCW]) <= MAX_VEC);
            end
        end
    end
endmodule

bind peer_setup_decoder peer_setup_decoder_chk #(
    .MAX_PEERS(MAX_PEERS), .MAX_VEC(MAX_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .own_id(own_id), .setup_done(setup_done),
    .setup_failed(setup_failed), .peer_count(peer_count),
    .vec_counts(vec_counts), .shm_evt(shm_evt), .conn_evt(conn_evt),
    .disc_evt(disc_evt), .evt_peer(evt_peer), .lvec_en(lvec_en),
    .err_pulse(err_pulse)
);

// File: tb/peer_setup_decoder_bench.sv
// Bench for peer_setup_decoder: table-driven message walk, then directed tests.
module peer_setup_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_PEERS = 32;
    localparam int MAX_VEC = 4;
    localparam int VCW = 3;
    localparam int PCW = 6;

    localparam logic [2:0] EV_NONE = 3'd0, EV_SHM = 3'd1, EV_CONN = 3'd2,
                           EV_DISC = 3'd3, EV_ERR = 3'd4;

    typedef struct packed {
        logic [63:0] val;
        logic        hnd;
        logic [2:0]  ev;
        logic [15:0] peer;
        logic        lv;
        logic [2:0]  lvn;
        logic [5:0]  pc;
        logic        chk;
        logic [2:0]  cnt;
    } step_t;

    localparam int NSTEP = 19;
    // own ID is 2; rows 0-2 run before setup completes
    localparam step_t STEPS [NSTEP] = '{
        '{64'd2,  1'b1, EV_CONN, 16'd2,  1'b1, 3'd0, 6'd16, 1'b1, 3'd1}, // R9
        '{64'd2,  1'b1, EV_CONN, 16'd2,  1'b1, 3'd1, 6'd16, 1'b1, 3'd2}, // R9
        '{64'd5,  1'b1, EV_CONN, 16'd5,  1'b0, 3'd0, 6'd16, 1'b1, 3'd1}, // R8
        '{'1,     1'b0, EV_SHM,  16'd0,  1'b0, 3'd0, 6'd16, 1'b0, 3'd0}, // R5
        '{'1,     1'b0, EV_ERR,  16'd0,  1'b0, 3'd0, 6'd16, 1'b0, 3'd0}, // R5
        '{64'd20, 1'b1, EV_CONN, 16'd20, 1'b0, 3'd0, 6'd21, 1'b1, 3'd1}, // R7
        '{64'd2,  1'b0, EV_ERR,  16'd2,  1'b0, 3'd0, 6'd21, 1'b1, 3'd2}, // R10
        '{64'd5,  1'b0, EV_DISC, 16'd5,  1'b0, 3'd0, 6'd21, 1'b1, 3'd0}, // R10
        '{64'h1_0000, 1'b0, EV_ERR, 16'd0, 1'b0, 3'd0, 6'd21, 1'b0, 3'd0}, // R6
        '{64'hFFFF_FFFF_FFFF_FFFE, 1'b1, EV_ERR, 16'd0, 1'b0, 3'd0, 6'd21, 1'b0, 3'd0}, // R6
        '{64'd40, 1'b1, EV_ERR,  16'd0,  1'b0, 3'd0, 6'd21, 1'b0, 3'd0}, // R7
        '{64'd7,  1'b1, EV_CONN, 16'd7,  1'b0, 3'd0, 6'd21, 1'b1, 3'd1}, // R8
        '{64'd7,  1'b1, EV_CONN, 16'd7,  1'b0, 3'd0, 6'd21, 1'b1, 3'd2}, // R8
        '{64'd7,  1'b1, EV_CONN, 16'd7,  1'b0, 3'd0, 6'd21, 1'b1, 3'd3}, // R8
        '{64'd7,  1'b1, EV_CONN, 16'd7,  1'b0, 3'd0, 6'd21, 1'b1, 3'd4}, // R8
        '{64'd7,  1'b1, EV_ERR,  16'd7,  1'b0, 3'd0, 6'd21, 1'b1, 3'd4}, // R8 cap
        '{64'd7,  1'b0, EV_DISC, 16'd7,  1'b0, 3'd0, 6'd21, 1'b1, 3'd0}, // R10
        '{64'd7,  1'b1, EV_CONN, 16'd7,  1'b0, 3'd0, 6'd21, 1'b1, 3'd1}, // R8
        '{64'd30, 1'b0, EV_DISC, 16'd30, 1'b0, 3'd0, 6'd31, 1'b1, 3'd0}  // R7
    };

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_handle = 1'b0;
    logic cfg_master = 1'b0;
    logic [7:0] in_byte = '0;
    logic [15:0] own_id, evt_peer;
    logic setup_done, setup_failed, shm_evt, conn_evt, disc_evt, lvec_en, err_pulse;
    logic [PCW-1:0] peer_count;
    logic [MAX_PEERS*VCW-1:0] vec_counts;
    logic [VCW-1:0] lvec_num;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic early_any, gone_any, s_lv;
    logic [2:0] s_ev, s_lvn;
    logic [15:0] s_peer;

    always #(CLK_PERIOD/2) clk = ~clk;

    peer_setup_decoder u_peer_setup_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_handle(in_handle), .cfg_master(cfg_master), .own_id(own_id),
        .setup_done(setup_done), .setup_failed(setup_failed),
        .peer_count(peer_count), .vec_counts(vec_counts), .shm_evt(shm_evt),
        .conn_evt(conn_evt), .disc_evt(disc_evt), .evt_peer(evt_peer),
        .lvec_en(lvec_en), .lvec_num(lvec_num), .err_pulse(err_pulse)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Send one message and snapshot outputs on the cycle its result shows.
    task automatic xfer(input logic [63:0] v, input logic h);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = v[i*8 +: 8];
            in_handle = (i == 7) ? h : 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b0; in_handle = 1'b0;
        early_any = shm_evt | conn_evt | disc_evt | err_pulse;
        @(negedge clk);
        s_ev = shm_evt ? EV_SHM : conn_evt ? EV_CONN : disc_evt ? EV_DISC :
               err_pulse ? EV_ERR : EV_NONE;
        s_lv = lvec_en; s_lvn = lvec_num; s_peer = evt_peer;
        @(negedge clk);
        gone_any = shm_evt | conn_evt | disc_evt | err_pulse;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk(own_id == 0 && !setup_done && !setup_failed, "R2 reset flags", {own_id, setup_done, setup_failed}, 0);
        chk(peer_count == 16, "R2 reset peer count", peer_count, 16);
        chk(vec_counts == '0, "R2 reset vector counts", vec_counts, 0);

        xfer(64'd0, 1'b0);
        chk(early_any == 0, "R1 no event before second edge", early_any, 0);
        chk(!setup_failed && s_ev == EV_NONE, "R3 version accepted", setup_failed, 0);
        xfer(64'd2, 1'b0);
        chk(own_id == 2 && !setup_failed, "R4 id captured", own_id, 2);

        for (int k = 0; k < NSTEP; k++) begin
            xfer(STEPS[k].val, STEPS[k].hnd);
            chk(s_ev == STEPS[k].ev, $sformatf("step %0d event (R5 R6 R7 R8 R10)", k), s_ev, STEPS[k].ev);
            chk(gone_any == 0, $sformatf("R12 step %0d single-cycle", k), gone_any, 0);
            chk(s_lv == STEPS[k].lv, $sformatf("R9 step %0d local enable", k), s_lv, STEPS[k].lv);
            if (STEPS[k].lv)
                chk(s_lvn == STEPS[k].lvn, $sformatf("R9 step %0d vector number", k), s_lvn, STEPS[k].lvn);
            if (STEPS[k].ev == EV_CONN || STEPS[k].ev == EV_DISC)
                chk(s_peer == STEPS[k].peer, $sformatf("R8 step %0d peer", k), s_peer, STEPS[k].peer);
            chk(32'(peer_count) == 32'(STEPS[k].pc), $sformatf("R7 step %0d peer count", k), peer_count, STEPS[k].pc);
            if (STEPS[k].chk)
                chk(vec_counts[STEPS[k].peer*VCW +: VCW] == STEPS[k].cnt,
                    $sformatf("R8 step %0d vector count", k),
                    vec_counts[STEPS[k].peer*VCW +: VCW], STEPS[k].cnt);
        end
        chk(setup_done && !setup_failed, "R5 setup done after table", setup_done, 1);

        // R2 reset from a busy state; R3 wrong version, R11 then silent
        do_reset();
        @(negedge clk);
        chk(peer_count == 16 && vec_counts == '0, "R2 reset clears table", peer_count, 16);
        xfer(64'd5, 1'b0);
        chk(setup_failed && s_ev == EV_ERR, "R3 wrong version fails", {setup_failed, s_ev}, {1'b1, EV_ERR});
        xfer(64'd0, 1'b0);
        chk(s_ev == EV_NONE && setup_failed, "R11 failed state ignores", s_ev, EV_NONE);
        xfer(64'd3, 1'b1);
        chk(s_ev == EV_NONE && vec_counts == '0 && peer_count == 16, "R11 no connect after fail", s_ev, EV_NONE);

        // R3 version with handle
        do_reset();
        xfer(64'd0, 1'b1);
        chk(setup_failed == 1, "R3 version with handle fails", setup_failed, 1);

        // R4 master with nonzero ID, then master with ID zero
        do_reset();
        cfg_master = 1'b1;
        xfer(64'd0, 1'b0);
        xfer(64'd3, 1'b0);
        chk(setup_failed && s_ev == EV_ERR, "R4 master nonzero id fails", setup_failed, 1);
        do_reset();
        xfer(64'd0, 1'b0);
        xfer(64'd0, 1'b0);
        chk(!setup_failed && own_id == 0, "R4 master id zero accepted", setup_failed, 0);
        cfg_master = 1'b0;

        // R4 ID with handle
        do_reset();
        xfer(64'd0, 1'b0);
        xfer(64'd4, 1'b1);
        chk(setup_failed == 1, "R4 id with handle fails", setup_failed, 1);

        // R1 byte order, then R6 invalid value during setup
        do_reset();
        xfer(64'd0, 1'b0);
        xfer(64'h0000_0000_0000_0102, 1'b0);
        chk(own_id == 16'h0102 && !setup_failed, "R1 little-endian assembly", own_id, 16'h0102);
        xfer(64'h0000_0000_0001_0000, 1'b0);
        chk(setup_failed && s_ev == EV_ERR, "R6 invalid value fails setup", setup_failed, 1);
        xfer('1, 1'b0);
        chk(!setup_done && s_ev == EV_NONE, "R11 shm ignored after fail", setup_done, 0);

        finish_run();
    end
endmodule